// File: doc/BRIEF.md
# Dual-Clock Presettable Up/Down Counter

This block is a binary up/down counter, four bits wide by default, with two separate count clocks. A rising edge on the up clock adds one to the count, and a rising edge on the down clock subtracts one. In each case the other count clock must be held high. The count can be cleared at any moment by a master clear. It can also be overwritten at any moment with a data word through an active-low load input. Both of these act on the count outputs at once, without waiting for a clock edge.

A free-running system clock samples the two count clocks through synchronizer flops and detects their rising edges. All counting therefore happens on system clock edges, and only clear and load act asynchronously.

Two active-low terminal-count outputs can drive the count clocks of a following stage, so stages can be chained into wider counters:
- The up output goes low while the count is at its maximum and the up clock is low.
- The down output goes low while the count is zero and the down clock is low.

All pins are plain control and status levels. The block carries no data stream, so it has no valid/ready handshake and no back-pressure.

Top module: `updn_dual_clk_counter`

## Requirements
- R1: A rising edge on `up_clk` while `dn_clk` is high increments the count by one.
- R2: A rising edge on `dn_clk` while `up_clk` is high decrements the count by one.
- R3: Counting wraps from the maximum (15 at WIDTH=4) to 0 going up, and from 0 to the maximum going down.
- R4: While `mclr` is high, `count_o` is 0 at once, whatever the clocks or `load_n` are doing. Clear has priority over load.
- R5: While `load_n` is low, `count_o` equals `data_i` at once, and count-clock edges have no effect. After `load_n` rises, the loaded value is held.
- R6: `tc_up_n` is low exactly when the count is at its maximum and the synchronized `up_clk` is low. Otherwise it is high.
- R7: `tc_dn_n` is low exactly when the count is 0 and the synchronized `dn_clk` is low. Otherwise it is high.
- R8: A rising edge on one count clock while the other is low is ignored. Rising edges on both clocks that are seen in the same system cycle are also ignored.
- R9: `count_o` changes on the third rising `clk` edge after a count-clock pin rises. The two synchronizer stages account for two edges and the count register for one. The count holds at all other times.
- R10: Wiring `tc_up_n`/`tc_dn_n` of one instance to `up_clk`/`dn_clk` of a second instance forms a counter of twice the width that counts and wraps correctly in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock that samples the count clocks |
| mclr | input | 1 | Master clear, active high, asynchronous |
| load_n | input | 1 | Parallel load, active low, asynchronous |
| data_i | input | WIDTH | Value copied into the count during a load |
| up_clk | input | 1 | Count-up clock; counts on its rising edge |
| dn_clk | input | 1 | Count-down clock; counts on its rising edge |
| count_o | output | WIDTH | Current count |
| tc_up_n | output | 1 | Up terminal count, active low |
| tc_dn_n | output | 1 | Down terminal count, active low |

## Verification
The bench builds the block with its defaults, WIDTH=4 and SYNC_STAGES=2. This keeps both wrap points within a few pulses and makes the three-edge latency an exact count of cycles.

A second instance of the same width, driven from the first instance's terminal-count outputs, forms an 8-bit chain. This brings carry and borrow across the stage boundary within reach in both directions. The clear-over-load priority and the ignored-edge cases are driven directly, and the count is checked right after each one.

// File: rtl/updn_pkg.sv
package updn_pkg;

  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_INC  = 2'd1,
    STEP_DEC  = 2'd2
  } step_e;

endpackage

// File: rtl/updn_edge_sync.sv
module updn_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic clr,
  input  logic lvl_in,
  output logic lvl_o,
  output logic rise_o
);

  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  // Flops reset to the idle-high level so that leaving clear never fakes an edge.
  always_ff @(posedge clk or posedge clr) begin
    if (clr) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], lvl_in};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign lvl_o  = sync_q[STAGES-1];
  assign rise_o = sync_q[STAGES-1] & ~prev_q;

  // R9
  rise_single_chk: assert property (@(posedge clk) disable iff (clr)
    rise_o |=> !rise_o);

endmodule

// File: rtl/updn_step_sel.sv
module updn_step_sel
  import updn_pkg::*;
(
  input  logic  clk,
  input  logic  clr,
  input  logic  up_rise,
  input  logic  dn_rise,
  input  logic  up_lvl,
  input  logic  dn_lvl,
  output step_e step_o
);

  always_comb begin
    step_o = STEP_HOLD;
    if (up_rise && !dn_rise && dn_lvl)
      step_o = STEP_INC;
    else if (dn_rise && !up_rise && up_lvl)
      step_o = STEP_DEC;
  end

  // R8
  dual_edge_hold_chk: assert property (@(posedge clk) disable iff (clr)
    (up_rise && dn_rise) |-> (step_o == STEP_HOLD));

  // R8
  no_inc_dn_low_chk: assert property (@(posedge clk) disable iff (clr)
    !dn_lvl |-> (step_o != STEP_INC));

endmodule

// File: rtl/updn_count_core.sv
module updn_count_core
  import updn_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             load_n,
  input  logic [WIDTH-1:0] data_i,
  input  step_e            step_i,
  output logic [WIDTH-1:0] cnt_o
);

  logic [WIDTH-1:0] cnt_q;

  always_ff @(posedge clk or posedge clr or negedge load_n) begin
    if (clr)
      cnt_q <= '0;
    else if (!load_n)
      cnt_q <= data_i;
    else begin
      case (step_i)
        STEP_INC: cnt_q <= cnt_q + 1'b1;
        STEP_DEC: cnt_q <= cnt_q - 1'b1;
        default:  cnt_q <= cnt_q;
      endcase
    end
  end

  assign cnt_o = cnt_q;

  // R1
  inc_step_chk: assert property (@(posedge clk) disable iff (clr || !load_n)
    (step_i == STEP_INC) |=> (cnt_q == WIDTH'($past(cnt_q) + 1'b1)));

  // R2
  dec_step_chk: assert property (@(posedge clk) disable iff (clr || !load_n)
    (step_i == STEP_DEC) |=> (cnt_q == WIDTH'($past(cnt_q) - 1'b1)));

  // R9
  hold_step_chk: assert property (@(posedge clk) disable iff (clr || !load_n)
    (step_i == STEP_HOLD) |=> $stable(cnt_q));

endmodule

// File: rtl/updn_tc_decode.sv
module updn_tc_decode #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             clr,
  input  logic [WIDTH-1:0] cnt_i,
  input  logic             up_lvl,
  input  logic             dn_lvl,
  output logic             tc_up_n,
  output logic             tc_dn_n
);

  localparam logic [WIDTH-1:0] CNT_MAX = '1;

  assign tc_up_n = ~((cnt_i == CNT_MAX) & ~up_lvl);
  assign tc_dn_n = ~((cnt_i == '0) & ~dn_lvl);

  // R6
  tc_up_high_chk: assert property (@(posedge clk) disable iff (clr)
    up_lvl |-> tc_up_n);

  // R7
  tc_dn_high_chk: assert property (@(posedge clk) disable iff (clr)
    dn_lvl |-> tc_dn_n);

endmodule

// File: rtl/updn_dual_clk_counter.sv
module updn_dual_clk_counter
  import updn_pkg::*;
#(
  parameter int WIDTH       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             mclr,
  input  logic             load_n,
  input  logic [WIDTH-1:0] data_i,
  input  logic             up_clk,
  input  logic             dn_clk,
  output logic [WIDTH-1:0] count_o,
  output logic             tc_up_n,
  output logic             tc_dn_n
);

  logic             up_lvl, up_rise, dn_lvl, dn_rise;
  step_e            step;
  logic [WIDTH-1:0] cnt_q;

  updn_edge_sync #(.STAGES(SYNC_STAGES)) up_sync_i (
    .clk(clk), .clr(mclr), .lvl_in(up_clk), .lvl_o(up_lvl), .rise_o(up_rise)
  );

  updn_edge_sync #(.STAGES(SYNC_STAGES)) dn_sync_i (
    .clk(clk), .clr(mclr), .lvl_in(dn_clk), .lvl_o(dn_lvl), .rise_o(dn_rise)
  );

  updn_step_sel step_i (
    .clk(clk), .clr(mclr), .up_rise(up_rise), .dn_rise(dn_rise),
    .up_lvl(up_lvl), .dn_lvl(dn_lvl), .step_o(step)
  );

  updn_count_core #(.WIDTH(WIDTH)) core_i (
    .clk(clk), .clr(mclr), .load_n(load_n), .data_i(data_i),
    .step_i(step), .cnt_o(cnt_q)
  );

  // Clear and load show through at once, even between system clock edges.
  always_comb begin
    if (mclr)
      count_o = '0;
    else if (!load_n)
      count_o = data_i;
    else
      count_o = cnt_q;
  end

  updn_tc_decode #(.WIDTH(WIDTH)) tc_i (
    .clk(clk), .clr(mclr), .cnt_i(count_o), .up_lvl(up_lvl), .dn_lvl(dn_lvl),
    .tc_up_n(tc_up_n), .tc_dn_n(tc_dn_n)
  );

  // R5
  load_hold_chk: assert property (@(posedge clk) disable iff (mclr)
    (!load_n && $past(!load_n) && $stable(data_i)) |-> $stable(count_o));

endmodule

// File: tb/updn_dual_clk_counter_tb.sv
module updn_dual_clk_counter_tb_top;

  logic       clk = 1'b0;
  logic       mclr = 1'b1;
  logic       load_n = 1'b1, load_hi_n = 1'b1;
  logic [3:0] data = 4'd0, data_hi = 4'd0;
  logic       up_clk = 1'b1, dn_clk = 1'b1;
  logic [3:0] q, q_hi;
  logic       tcu_n, tcd_n, tcu_hi_n, tcd_hi_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  updn_dual_clk_counter dut_i (
    .clk(clk), .mclr(mclr), .load_n(load_n), .data_i(data),
    .up_clk(up_clk), .dn_clk(dn_clk), .count_o(q),
    .tc_up_n(tcu_n), .tc_dn_n(tcd_n)
  );

  // Upper stage of the cascade, clocked by the terminal-count outputs.
  updn_dual_clk_counter dut_hi (
    .clk(clk), .mclr(mclr), .load_n(load_hi_n), .data_i(data_hi),
    .up_clk(tcu_n), .dn_clk(tcd_n), .count_o(q_hi),
    .tc_up_n(tcu_hi_n), .tc_dn_n(tcd_hi_n)
  );

  // Vector: [5:4] = 01 up pulse, 10 down pulse; [3:0] = expected count.
  localparam logic [5:0] VEC [0:11] = '{
    6'h1E, 6'h1F, 6'h10, 6'h11, 6'h20, 6'h2F,
    6'h2E, 6'h1F, 6'h10, 6'h2F, 6'h2E, 6'h2D
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_up();
    up_clk = 1'b0; cyc(3);
    up_clk = 1'b1; cyc(5);
  endtask

  task automatic pulse_dn();
    dn_clk = 1'b0; cyc(3);
    dn_clk = 1'b1; cyc(5);
  endtask

  task automatic load_val(input logic [3:0] v);
    data = v; load_n = 1'b0; cyc(2);
    load_n = 1'b1; cyc(1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    cyc(3);
    // R4: reset state
    check("R4 reset count", q, 0);
    check("R6 reset tc_up_n", tcu_n, 1);
    check("R7 reset tc_dn_n", tcd_n, 1);
    mclr = 1'b0; cyc(2);

    // Table walk from 13: R1 R2 R3
    load_val(4'd13);
    for (int i = 0; i < 12; i++) begin
      if (VEC[i][5:4] == 2'b01) pulse_up(); else pulse_dn();
      check(VEC[i][4] ? "R1/R3 up step" : "R2/R3 down step", q, VEC[i][3:0]);
    end

    // R9: latency of three system edges
    load_val(4'd5);
    up_clk = 1'b0; cyc(3);
    up_clk = 1'b1; cyc(2);
    check("R9 before third edge", q, 5);
    cyc(1);
    check("R9 at third edge", q, 6);
    cyc(3);

    // R6: up terminal count
    load_val(4'd15);
    check("R6 tc_up_n high while up_clk high", tcu_n, 1);
    up_clk = 1'b0; cyc(3);
    check("R6 tc_up_n low at max", tcu_n, 0);
    up_clk = 1'b1; cyc(5);
    check("R6 tc_up_n released", tcu_n, 1);
    check("R3 wrap to zero", q, 0);

    // R7: down terminal count
    dn_clk = 1'b0; cyc(3);
    check("R7 tc_dn_n low at zero", tcd_n, 0);
    dn_clk = 1'b1; cyc(5);
    check("R7 tc_dn_n released", tcd_n, 1);
    check("R3 wrap to max", q, 15);

    // R8: up edge while down low ignored
    load_val(4'd7);
    up_clk = 1'b0; cyc(3);
    dn_clk = 1'b0; cyc(3);
    up_clk = 1'b1; cyc(5);
    check("R8 up edge with dn low ignored", q, 7);
    dn_clk = 1'b1; cyc(5);
    check("R2 down edge after ignored up", q, 6);

    // R8: simultaneous edges ignored
    up_clk = 1'b0; dn_clk = 1'b0; cyc(3);
    up_clk = 1'b1; dn_clk = 1'b1; cyc(5);
    check("R8 simultaneous edges ignored", q, 6);

    // R5: load transparent, overrides edges, holds after release
    data = 4'd9; load_n = 1'b0; #1;
    check("R5 load immediate", q, 9);
    up_clk = 1'b0; cyc(3);
    up_clk = 1'b1; cyc(5);
    check("R5 edge during load ignored", q, 9);
    load_n = 1'b1; cyc(3);
    check("R5 value held after load", q, 9);

    // R4: clear wins over load and is immediate
    data = 4'd11; load_n = 1'b0; mclr = 1'b1; #1;
    check("R4 clear over load", q, 0);
    cyc(1);
    load_n = 1'b1; cyc(1);
    mclr = 1'b0; cyc(2);
    check("R4 stays zero after clear", q, 0);

    // R10: 8-bit cascade
    load_val(4'd10);
    data_hi = 4'd15; load_hi_n = 1'b0; cyc(2); load_hi_n = 1'b1; cyc(2);
    for (int i = 0; i < 20; i++) pulse_up();
    cyc(4);
    check("R10 cascade up with carry wrap", {q_hi, q}, 14);
    for (int i = 0; i < 30; i++) pulse_dn();
    cyc(4);
    check("R10 cascade down with borrow wrap", {q_hi, q}, 240);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule